// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Flag Bank

This block keeps the status flags of a combined master/slave I2C controller and merges them into one interrupt request. It sits between the bus-side engine and the processor's register interface. The engine reports single-cycle event strobes: byte received, own address matched, general call seen, first address byte with its direction bit, arbitration lost, STOP seen, repeated START seen, and not-acknowledge. The processor side reports strobes for reading the status register, for reading the data register, and for software issuing a START or STOP command.

Each flag has its own set condition and its own clear condition. Depending on the flag, it clears on a status read, on a data read, on a new START/STOP command, or when the controller is disabled. If a set event and a clear strobe arrive in the same clock, the set takes effect.

A small transaction tracker with three states decides whether a STOP or repeated START belongs to a transaction addressed to this slave:
- `TXN_OFF`: the controller is disabled.
- `TXN_IDLE`: the controller is enabled but not addressed.
- `TXN_ADDRESSED`: a slave address match has been seen.

Its transitions are:
- OFF→IDLE when enable rises.
- OFF→ADDRESSED when enable rises in the same cycle as a slave address match.
- IDLE→ADDRESSED on a slave address match.
- ADDRESSED→IDLE on STOP or repeated START.
- Any state→OFF when enable is low.

Top module: `i2c_flag_bank`

## Requirements
- R1: After reset, `flags`, `dir_read`, `gcall_seen`, `end_was_restart` and `irq` are all 0.
- R2: `flags[0]` (receive byte ready) sets the cycle after `ev_rx_byte`. It clears after `rd_data`, and `rd_status` leaves it unchanged.
- R3: `flags[1]` (own address matched) sets after `ev_addr_match` only when `master_mode` is 0. It clears after `rd_status`.
- R4: `flags[2]` (arbitration lost) sets after `ev_arb_lost` only when `master_mode` is 1. It clears after `rd_status`.
- R5: `flags[3]` (transaction ended) sets after `ev_stop` or `ev_restart` only in slave mode while the tracker is in `TXN_ADDRESSED`. It clears after `rd_status`. When it sets, `end_was_restart` takes the value of `ev_restart` (1 = repeated START, 0 = STOP).
- R6: In master mode, `flags[4]` (not-acknowledge) sets after `ev_nak` only while `cmd_pending` is 0. It clears only after `sw_cmd_set`; `rd_status` leaves it unchanged.
- R7: In slave mode, `flags[4]` sets after `ev_nak` and clears after `rd_status`.
- R8: On `ev_first_addr`, `dir_read` takes `ev_addr_lsb` (1 = master reads). At all other times it holds its value.
- R9: On a slave address match, `gcall_seen` takes the value of `ev_gcall`.
- R10: When a flag's set event and its clear strobe occur in the same cycle, the flag ends up set.
- R11: `irq` is 1 exactly when `enable` is 1 and some bit of `flags & irq_mask` is 1.
- R12: While `enable` is 0, all flags, `dir_read`, `gcall_seen` and `end_was_restart` are cleared the following cycle and no event sets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low clears all state |
| master_mode | input | 1 | 1 = master, 0 = slave |
| irq_mask | input | 5 | Per-flag interrupt enables |
| ev_rx_byte | input | 1 | A complete byte was received |
| ev_addr_match | input | 1 | Own or general-call address received |
| ev_gcall | input | 1 | The matched address was a general call |
| ev_first_addr | input | 1 | First address byte after START finished |
| ev_addr_lsb | input | 1 | LSB of that address byte |
| ev_arb_lost | input | 1 | Drove 1 on SDA but sampled 0 |
| ev_stop | input | 1 | STOP detected |
| ev_restart | input | 1 | Repeated START detected |
| ev_nak | input | 1 | Not-acknowledge sent or received |
| cmd_pending | input | 1 | A START or STOP command is pending |
| sw_cmd_set | input | 1 | Software writes a START or STOP command |
| rd_status | input | 1 | Status register read strobe |
| rd_data | input | 1 | Data register read strobe |
| flags | output | 5 | Flag vector (bit order as in R2–R7) |
| dir_read | output | 1 | Transfer direction, 1 = master reads |
| gcall_seen | output | 1 | Last slave match was a general call |
| end_was_restart | output | 1 | Last transaction end was a repeated START |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences cover three patterns:
- A byte followed by a status read and then a data read, which shows that the clear strobes belong to their own flags.
- A set strobe and a clear strobe in the same cycle.
- A not-acknowledge in master mode followed by status reads, which shows that only the command write clears it.

Random streams from a fixed seed then mix events, read strobes, mode changes, enable drops and mask changes. Every cycle they are compared against a bench model of the requirements. The STOP/restart events that arrive outside an addressed transaction check the tracker's states, and the enable drops check its OFF state.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
    parameter int NUM_FLAGS = 5;
    localparam int F_RXBYTE = 0;
    localparam int F_ADDR   = 1;
    localparam int F_ARB    = 2;
    localparam int F_ENDTXN = 3;
    localparam int F_NAK    = 4;

    typedef enum logic [1:0] {
        TXN_OFF       = 2'd0,
        TXN_IDLE      = 2'd1,
        TXN_ADDRESSED = 2'd2
    } txn_state_t;
endpackage

// File: rtl/i2c_txn_fsm.sv
module i2c_txn_fsm
    import i2c_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic addr_hit,
    input  logic end_evt,
    output logic in_txn
);
    txn_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXN_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            TXN_OFF: begin
                if (enable) state_nxt = addr_hit ? TXN_ADDRESSED : TXN_IDLE;
            end
            TXN_IDLE: begin
                if (!enable)       state_nxt = TXN_OFF;
                else if (addr_hit) state_nxt = TXN_ADDRESSED;
            end
            TXN_ADDRESSED: begin
                if (!enable)      state_nxt = TXN_OFF;
                else if (end_evt) state_nxt = TXN_IDLE;
            end
            default: state_nxt = TXN_OFF;
        endcase
    end

    always_comb begin
        in_txn = (state == TXN_ADDRESSED);
    end
endmodule

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Priority: disable kill, then set, then clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= 1'b0;
        else if (kill) q <= 1'b0;
        else if (set)  q <= 1'b1;
        else if (clr)  q <= 1'b0;
    end
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank
    import i2c_flag_pkg::*;
#(
    parameter int NF = NUM_FLAGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          master_mode,
    input  logic [NF-1:0] irq_mask,
    input  logic          ev_rx_byte,
    input  logic          ev_addr_match,
    input  logic          ev_gcall,
    input  logic          ev_first_addr,
    input  logic          ev_addr_lsb,
    input  logic          ev_arb_lost,
    input  logic          ev_stop,
    input  logic          ev_restart,
    input  logic          ev_nak,
    input  logic          cmd_pending,
    input  logic          sw_cmd_set,
    input  logic          rd_status,
    input  logic          rd_data,
    output logic [NF-1:0] flags,
    output logic          dir_read,
    output logic          gcall_seen,
    output logic          end_was_restart,
    output logic          irq
);
    logic [NF-1:0] set_v, clr_v;
    logic kill, slave_hit, end_evt, in_txn;

    assign kill      = !enable;
    assign slave_hit = ev_addr_match && !master_mode;
    assign end_evt   = ev_stop || ev_restart;

    i2c_txn_fsm u_txn (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .addr_hit (slave_hit),
        .end_evt  (end_evt),
        .in_txn   (in_txn)
    );

    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[F_RXBYTE] = ev_rx_byte;
        clr_v[F_RXBYTE] = rd_data;
        set_v[F_ADDR]   = slave_hit;
        clr_v[F_ADDR]   = rd_status;
        set_v[F_ARB]    = ev_arb_lost && master_mode;
        clr_v[F_ARB]    = rd_status;
        set_v[F_ENDTXN] = end_evt && !master_mode && in_txn;
        clr_v[F_ENDTXN] = rd_status;
        if (master_mode) begin
            set_v[F_NAK] = ev_nak && !cmd_pending;
            clr_v[F_NAK] = sw_cmd_set;
        end else begin
            set_v[F_NAK] = ev_nak;
            clr_v[F_NAK] = rd_status;
        end
    end

    for (genvar i = 0; i < NF; i++) begin : g_flag
        i2c_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .kill  (kill),
            .set   (set_v[i]),
            .clr   (clr_v[i]),
            .q     (flags[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_read        <= 1'b0;
            gcall_seen      <= 1'b0;
            end_was_restart <= 1'b0;
        end else if (kill) begin
            dir_read        <= 1'b0;
            gcall_seen      <= 1'b0;
            end_was_restart <= 1'b0;
        end else begin
            if (ev_first_addr)   dir_read        <= ev_addr_lsb;
            if (slave_hit)       gcall_seen      <= ev_gcall;
            if (set_v[F_ENDTXN]) end_was_restart <= ev_restart;
        end
    end

    assign irq = enable && |(flags & irq_mask);
endmodule

// File: rtl/i2c_flag_bank_chk.sv
module i2c_flag_bank_chk #(
    parameter int NF = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          master_mode,
    input logic          ev_rx_byte,
    input logic          ev_arb_lost,
    input logic          ev_first_addr,
    input logic          ev_addr_lsb,
    input logic          sw_cmd_set,
    input logic          rd_data,
    input logic [NF-1:0] flags,
    input logic          dir_read,
    input logic          gcall_seen,
    input logic          irq
);
    p_rx_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable && rd_data && !ev_rx_byte |=> !flags[0]);

    p_arb_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(master_mode));

    p_nak_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enable && master_mode && flags[4] && !sw_cmd_set |=> flags[4]);

    p_dir_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enable && ev_first_addr |=> dir_read == $past(ev_addr_lsb));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        enable && ev_rx_byte |=> flags[0]);

    p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !irq);

    p_kill_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (flags == '0) && !dir_read && !gcall_seen);

    p_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && ev_arb_lost |=> !flags[2]);
endmodule

bind i2c_flag_bank i2c_flag_bank_chk #(.NF(NF)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .master_mode   (master_mode),
    .ev_rx_byte    (ev_rx_byte),
    .ev_arb_lost   (ev_arb_lost),
    .ev_first_addr (ev_first_addr),
    .ev_addr_lsb   (ev_addr_lsb),
    .sw_cmd_set    (sw_cmd_set),
    .rd_data       (rd_data),
    .flags         (flags),
    .dir_read      (dir_read),
    .gcall_seen    (gcall_seen),
    .irq           (irq)
);

// File: tb/sim_i2c_flag_bank.sv
module sim_i2c_flag_bank;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, master_mode = 1'b0;
    logic [4:0] irq_mask = 5'h1f;
    logic ev_rx_byte = 0, ev_addr_match = 0, ev_gcall = 0, ev_first_addr = 0, ev_addr_lsb = 0;
    logic ev_arb_lost = 0, ev_stop = 0, ev_restart = 0, ev_nak = 0, cmd_pending = 0;
    logic sw_cmd_set = 0, rd_status = 0, rd_data = 0;
    logic [4:0] flags;
    logic dir_read, gcall_seen, end_was_restart, irq;

    int n_checks = 0, n_errors = 0;

    // bench model
    logic [4:0] m_flags = '0;
    logic m_dir = 0, m_gca = 0, m_kind = 0;
    int m_st = 0; // 0 off, 1 idle, 2 addressed

    always #5 clk = ~clk;

    i2c_flag_bank u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master_mode(master_mode),
        .irq_mask(irq_mask), .ev_rx_byte(ev_rx_byte), .ev_addr_match(ev_addr_match),
        .ev_gcall(ev_gcall), .ev_first_addr(ev_first_addr), .ev_addr_lsb(ev_addr_lsb),
        .ev_arb_lost(ev_arb_lost), .ev_stop(ev_stop), .ev_restart(ev_restart),
        .ev_nak(ev_nak), .cmd_pending(cmd_pending), .sw_cmd_set(sw_cmd_set),
        .rd_status(rd_status), .rd_data(rd_data), .flags(flags), .dir_read(dir_read),
        .gcall_seen(gcall_seen), .end_was_restart(end_was_restart), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        logic [4:0] s, c;
        logic hit, endv;
        hit  = ev_addr_match && !master_mode;
        endv = ev_stop || ev_restart;
        s[0] = ev_rx_byte;                 c[0] = rd_data;
        s[1] = hit;                        c[1] = rd_status;
        s[2] = ev_arb_lost && master_mode; c[2] = rd_status;
        s[3] = endv && !master_mode && (m_st == 2); c[3] = rd_status;
        s[4] = ev_nak && (master_mode ? !cmd_pending : 1'b1);
        c[4] = master_mode ? sw_cmd_set : rd_status;
        if (!enable) begin
            m_flags = '0; m_dir = 0; m_gca = 0; m_kind = 0;
        end else begin
            m_flags = s | (m_flags & ~c);
            if (ev_first_addr) m_dir = ev_addr_lsb;
            if (hit) m_gca = ev_gcall;
            if (s[3]) m_kind = ev_restart;
        end
        case (m_st)
            0: if (enable) m_st = hit ? 2 : 1;
            1: if (!enable) m_st = 0; else if (hit) m_st = 2;
            default: if (!enable) m_st = 0; else if (endv) m_st = 1;
        endcase
    endtask

    task automatic compare_all();
        check(flags[0] == m_flags[0], "R2 rx flag", flags[0], m_flags[0]);
        check(flags[1] == m_flags[1], "R3 addr flag", flags[1], m_flags[1]);
        check(flags[2] == m_flags[2], "R4 arb flag", flags[2], m_flags[2]);
        check(flags[3] == m_flags[3], "R5 end flag", flags[3], m_flags[3]);
        check(flags[4] == m_flags[4], master_mode ? "R6 nak flag" : "R7 nak flag",
              flags[4], m_flags[4]);
        check(end_was_restart == m_kind, "R5 end kind", end_was_restart, m_kind);
        check(dir_read == m_dir, "R8 direction", dir_read, m_dir);
        check(gcall_seen == m_gca, "R9 general call", gcall_seen, m_gca);
        check(irq == (enable && |(m_flags & irq_mask)), "R11 irq", irq,
              enable && |(m_flags & irq_mask));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_strobes();
        ev_rx_byte = 0; ev_addr_match = 0; ev_gcall = 0; ev_first_addr = 0;
        ev_arb_lost = 0; ev_stop = 0; ev_restart = 0; ev_nak = 0;
        sw_cmd_set = 0; rd_status = 0; rd_data = 0;
    endtask

    initial begin
        #2000000;
        check(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check(flags == 0 && !dir_read && !gcall_seen && !end_was_restart && !irq,
              "R1 reset state", {flags, dir_read, gcall_seen, end_was_restart, irq}, 0);
        rst_n = 1;
        @(negedge clk);
        enable = 1; step();

        // R2: byte, status read keeps it, data read clears it
        ev_rx_byte = 1; step(); clear_strobes();
        check(flags[0] == 1, "R2 set", flags[0], 1);
        rd_status = 1; step(); clear_strobes();
        check(flags[0] == 1, "R2 status read ignored", flags[0], 1);
        rd_data = 1; step(); clear_strobes();
        check(flags[0] == 0, "R2 data read clears", flags[0], 0);

        // R10: set and clear together
        ev_rx_byte = 1; rd_data = 1; step(); clear_strobes();
        check(flags[0] == 1, "R10 set wins", flags[0], 1);

        // R3/R5/R9: slave addressed, then restart ends it
        ev_addr_match = 1; ev_gcall = 1; step(); clear_strobes();
        check(flags[1] == 1 && gcall_seen == 1, "R3 R9 match", {flags[1], gcall_seen}, 3);
        ev_restart = 1; step(); clear_strobes();
        check(flags[3] == 1 && end_was_restart == 1, "R5 restart", {flags[3], end_was_restart}, 3);
        rd_status = 1; step(); clear_strobes();
        check(flags[3:1] == 0, "R5 status read clears", flags[3:1], 0);
        ev_stop = 1; step(); clear_strobes();
        check(flags[3] == 0, "R5 stop outside transaction", flags[3], 0);

        // R6: master NAK
        master_mode = 1; ev_nak = 1; cmd_pending = 1; step(); clear_strobes();
        check(flags[4] == 0, "R6 nak blocked by pending command", flags[4], 0);
        cmd_pending = 0; ev_nak = 1; step(); clear_strobes();
        check(flags[4] == 1, "R6 nak set", flags[4], 1);
        rd_status = 1; step(); clear_strobes();
        check(flags[4] == 1, "R6 status read ignored", flags[4], 1);
        sw_cmd_set = 1; step(); clear_strobes();
        check(flags[4] == 0, "R6 command clears", flags[4], 0);

        // R8 direction
        ev_first_addr = 1; ev_addr_lsb = 1; step(); clear_strobes();
        check(dir_read == 1, "R8 direction load", dir_read, 1);

        // R12 disable
        ev_arb_lost = 1; step(); clear_strobes();
        enable = 0; ev_arb_lost = 1; ev_rx_byte = 1; step(); clear_strobes();
        check(flags == 0 && !dir_read && !irq, "R12 disable clears", {flags, dir_read, irq}, 0);
        enable = 1;

        // random phase
        for (int i = 0; i < 4000; i++) begin
            enable        = ($urandom % 100) < 96;
            if (($urandom % 100) < 4) master_mode = ~master_mode;
            if (($urandom % 100) < 3) irq_mask = $urandom;
            ev_rx_byte    = ($urandom % 100) < 15;
            ev_addr_match = ($urandom % 100) < 12;
            ev_gcall      = $urandom % 2;
            ev_first_addr = ($urandom % 100) < 12;
            ev_addr_lsb   = $urandom % 2;
            ev_arb_lost   = ($urandom % 100) < 10;
            ev_stop       = ($urandom % 100) < 8;
            ev_restart    = ($urandom % 100) < 8;
            ev_nak        = ($urandom % 100) < 12;
            cmd_pending   = ($urandom % 100) < 30;
            sw_cmd_set    = ($urandom % 100) < 10;
            rd_status     = ($urandom % 100) < 20;
            rd_data       = ($urandom % 100) < 20;
            step();
        end
        clear_strobes();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule